// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps large, aligned regions of the effective address space straight to real memory. It does not walk a page table. It keeps two register sets of `N_ENT` entry pairs each: one set serves instruction fetches and the other serves loads and stores. Each pair has an upper word, which gives the effective base, the size mask and the privilege enables. It also has a lower word, which gives the real base and the permission code. Every lookup compares its address against all entries of the selected set at once. The lowest-indexed entry that matches and is enabled decides the outcome.

A lookup request carries an effective address, an access kind and a user/supervisor flag. One cycle later the block returns four results: hit, granted, fault, and the real address. A miss means nothing in the set claimed the address, so the surrounding translation logic moves on to segment-based translation. Software or a sequencer loads the entries through a simple write port that selects the set, the index and the word half.

Top module: `blkxl_matcher`

## Requirements
- R1: After reset every stored word is zero, so every lookup misses until entries are written.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise.
- R3: An entry matches when EA[31:28] equals upper[31:28] and EA[27:17], with the mask bits cleared, equals upper[27:17]. The mask is upper[12:2] placed on EA bits 27:17.
- R4: upper bit 1 enables an entry for supervisor accesses (`req_user`=0) and upper bit 0 enables it for user accesses (`req_user`=1). A matching entry that is not enabled is skipped.
- R5: The permission code is lower[1:0]. Code 0 allows nothing, code 2 allows load, store and fetch, and codes 1 and 3 allow load and fetch only. A hit whose code forbids the access gives `rsp_fault`=1 and `rsp_grant`=0.
- R6: On a hit the real address is built from four parts. Bits 31:28 come from lower[31:28]. Bits 27:17 are (EA[27:17] AND mask) OR lower[27:17]. Bits 16:0 are copied from EA.
- R7: `req_kind` is 0 for load, 1 for store and 2 for fetch. A fetch searches only the instruction set. A load or a store searches only the data set.
- R8: The lowest-indexed enabled matching entry decides the outcome alone, even when it faults and a higher entry would grant.
- R9: On a miss, `rsp_hit`, `rsp_grant` and `rsp_fault` are 0 and `rsp_raddr` is 0.
- R10: A write and a lookup in the same cycle use the contents from before the write. The write is seen by the next lookup.
- R11: While `rsp_valid` is low, `rsp_hit`, `rsp_grant`, `rsp_fault` and `rsp_raddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_space | input | 1 | Set select: 0 data, 1 instruction |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_half | input | 1 | Word select: 0 upper, 1 lower |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for user-mode access, 0 for supervisor |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | An enabled entry matched |
| rsp_grant | output | 1 | Hit and access permitted |
| rsp_fault | output | 1 | Hit but access forbidden |
| rsp_raddr | output | 32 | Translated real address |

## Verification
Two functions can fall in the same clock edge: an entry write and a lookup. The bench provokes this by driving a write strobe that disables data entry 0 in the same cycle as a supervisor load that only that entry serves at a higher priority. The first response must still show entry 0's translation. The next lookup, with the write now in place, must fall through to entry 2 and return that entry's real base. That sequence shows both the old-contents rule and the priority fallback.

// File: rtl/blkxl_pkg.sv
package blkxl_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned HI_LSB  = 28;
    localparam int unsigned MID_LSB = 17;
    localparam int unsigned HI_W    = ADDR_W - HI_LSB;
    localparam int unsigned MID_W   = HI_LSB - MID_LSB;
    localparam int unsigned MASK_LSB = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic [HI_W-1:0]  ea_hi;
        logic [MID_W-1:0] ea_mid;
        logic [MID_W-1:0] len_mask;
        logic             en_sup;
        logic             en_usr;
    } up_word_t;

    typedef struct packed {
        logic [HI_W-1:0]  ra_hi;
        logic [MID_W-1:0] ra_mid;
        logic [1:0]       perm;
    } lo_word_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef struct packed {
        logic              hit;
        logic              grant;
        logic              fault;
        logic [ADDR_W-1:0] raddr;
    } xl_result_t;

    function automatic up_word_t unpack_up(input logic [ADDR_W-1:0] w);
        up_word_t u;
        u.ea_hi    = w[ADDR_W-1:HI_LSB];
        u.ea_mid   = w[HI_LSB-1:MID_LSB];
        u.len_mask = w[MASK_LSB+MID_W-1:MASK_LSB];
        u.en_sup   = w[1];
        u.en_usr   = w[0];
        return u;
    endfunction

    function automatic lo_word_t unpack_lo(input logic [ADDR_W-1:0] w);
        lo_word_t l;
        l.ra_hi  = w[ADDR_W-1:HI_LSB];
        l.ra_mid = w[HI_LSB-1:MID_LSB];
        l.perm   = w[1:0];
        return l;
    endfunction

    function automatic rights_t perm_rights(input logic [1:0] code);
        rights_t r;
        r.rd = (code != 2'd0);
        r.ex = (code != 2'd0);
        r.wr = (code == 2'd2);
        return r;
    endfunction

    function automatic logic rights_allow(input rights_t r, input acc_kind_e k);
        logic ok;
        case (k)
            ACC_LOAD:  ok = r.rd;
            ACC_STORE: ok = r.wr;
            ACC_FETCH: ok = r.ex;
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/blkxl_regfile.sv
module blkxl_regfile
    import blkxl_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int unsigned N_SPACE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_space,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_half,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_space,
    output up_word_t          up_sel [N_ENT],
    output lo_word_t          lo_sel [N_ENT]
);

    up_word_t up_all [N_SPACE][N_ENT];
    lo_word_t lo_all [N_SPACE][N_ENT];

    for (genvar s = 0; s < N_SPACE; s++) begin : g_space
        for (genvar e = 0; e < N_ENT; e++) begin : g_ent
            logic     this_ent;
            up_word_t up_q;
            lo_word_t lo_q;

            assign this_ent = wr_en && (wr_space == 1'(s)) && (wr_idx == IDX_W'(e));

            always_ff @(posedge clk) begin
                if (rst) begin
                    up_q <= '0;
                    lo_q <= '0;
                end else if (this_ent) begin
                    if (wr_half) begin
                        lo_q <= unpack_lo(wr_data);
                    end else begin
                        up_q <= unpack_up(wr_data);
                    end
                end
            end

            assign up_all[s][e] = up_q;
            assign lo_all[s][e] = lo_q;
        end
    end

    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            up_sel[e] = rd_space ? up_all[1][e] : up_all[0][e];
            lo_sel[e] = rd_space ? lo_all[1][e] : lo_all[0][e];
        end
    end

endmodule

// File: rtl/blkxl_entry_cmp.sv
module blkxl_entry_cmp
    import blkxl_pkg::*;
(
    input  up_word_t          up,
    input  lo_word_t          lo,
    input  logic [ADDR_W-1:0] ea,
    input  acc_kind_e         kind,
    input  logic              user,
    output logic              selected,
    output logic              allowed,
    output logic [ADDR_W-1:0] raddr
);

    logic [MID_W-1:0] ea_mid;
    logic             hi_eq;
    logic             mid_eq;
    logic             enabled;
    rights_t          rights;

    assign ea_mid  = ea[HI_LSB-1:MID_LSB];
    assign hi_eq   = (ea[ADDR_W-1:HI_LSB] == up.ea_hi);
    assign mid_eq  = ((ea_mid & ~up.len_mask) == up.ea_mid);
    assign enabled = user ? up.en_usr : up.en_sup;

    assign selected = hi_eq && mid_eq && enabled;

    assign rights  = perm_rights(lo.perm);
    assign allowed = rights_allow(rights, kind);

    assign raddr = {lo.ra_hi,
                    (ea_mid & up.len_mask) | lo.ra_mid,
                    ea[MID_LSB-1:0]};

endmodule

// File: rtl/blkxl_prio_sel.sv
module blkxl_prio_sel
    import blkxl_pkg::*;
#(
    parameter int unsigned N_ENT = 4
) (
    input  logic              sel     [N_ENT],
    input  logic              allowed [N_ENT],
    input  logic [ADDR_W-1:0] raddr   [N_ENT],
    output xl_result_t        result
);

    always_comb begin
        logic found;
        found  = 1'b0;
        result = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found && sel[i]) begin
                found        = 1'b1;
                result.hit   = 1'b1;
                result.grant = allowed[i];
                result.fault = !allowed[i];
                result.raddr = raddr[i];
            end
        end
    end

endmodule

// File: rtl/blkxl_matcher.sv
module blkxl_matcher
    import blkxl_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_space,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_half,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       req_ea,
    input  logic [1:0]        req_kind,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_grant,
    output logic              rsp_fault,
    output logic [31:0]       rsp_raddr
);

    acc_kind_e kind;
    logic      use_instr;
    up_word_t  up_sel [N_ENT];
    lo_word_t  lo_sel [N_ENT];
    logic      ent_sel   [N_ENT];
    logic      ent_allow [N_ENT];
    logic [ADDR_W-1:0] ent_raddr [N_ENT];
    xl_result_t pick;
    xl_result_t rsp_q;
    logic       rsp_valid_q;

    assign kind      = acc_kind_e'(req_kind);
    assign use_instr = (kind == ACC_FETCH);

    blkxl_regfile #(.N_ENT(N_ENT)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_we),
        .wr_space (cfg_space),
        .wr_idx   (cfg_idx),
        .wr_half  (cfg_half),
        .wr_data  (cfg_wdata),
        .rd_space (use_instr),
        .up_sel   (up_sel),
        .lo_sel   (lo_sel)
    );

    for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
        blkxl_entry_cmp cmp_i (
            .up       (up_sel[e]),
            .lo       (lo_sel[e]),
            .ea       (req_ea),
            .kind     (kind),
            .user     (req_user),
            .selected (ent_sel[e]),
            .allowed  (ent_allow[e]),
            .raddr    (ent_raddr[e])
        );
    end

    blkxl_prio_sel #(.N_ENT(N_ENT)) prio_i (
        .sel     (ent_sel),
        .allowed (ent_allow),
        .raddr   (ent_raddr),
        .result  (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            rsp_q       <= req_valid ? pick : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_grant = rsp_q.grant;
    assign rsp_fault = rsp_q.fault;
    assign rsp_raddr = rsp_q.raddr;

endmodule

// File: rtl/blkxl_checker.sv
module blkxl_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_ea,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_grant,
    input logic        rsp_fault,
    input logic [31:0] rsp_raddr
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                   // R2

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);                                 // R2

    AST_GRANT_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rsp_grant && rsp_fault));                                 // R5

    AST_OUTCOME_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant || rsp_fault) |-> rsp_hit);                      // R9

    AST_HIT_HAS_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_grant || rsp_fault));                      // R8

    AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_raddr == 32'd0));          // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_grant && !rsp_fault && rsp_raddr == 32'd0)); // R11

    AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid ##1 rsp_hit) |-> (rsp_raddr[16:0] == $past(req_ea[16:0]))); // R6

endmodule

bind blkxl_matcher blkxl_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ea    (req_ea),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_grant (rsp_grant),
    .rsp_fault (rsp_fault),
    .rsp_raddr (rsp_raddr)
);

// File: tb/blkxl_matcher_tb_top.sv
`timescale 1ns/1ps
module blkxl_matcher_tb_top;

    localparam int N_ENT = 4;
    localparam int IDX_W = 2;
    localparam int N_VEC = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we = 1'b0;
    logic             cfg_space = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic             cfg_half = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic             req_valid = 1'b0;
    logic [31:0]      req_ea = '0;
    logic [1:0]       req_kind = '0;
    logic             req_user = 1'b0;
    logic             rsp_valid, rsp_hit, rsp_grant, rsp_fault;
    logic [31:0]      rsp_raddr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    blkxl_matcher #(.N_ENT(N_ENT)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_space(cfg_space), .cfg_idx(cfg_idx),
        .cfg_half(cfg_half), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ea(req_ea), .req_kind(req_kind), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_grant(rsp_grant),
        .rsp_fault(rsp_fault), .rsp_raddr(rsp_raddr)
    );

    // {ea, kind, user, hit, grant, fault, raddr}; kind 0 load, 1 store, 2 fetch
    localparam logic [69:0] VEC [N_VEC] = '{
        {32'h1001_2345, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h8001_2345},
        {32'h1001_2345, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h8001_2345},
        {32'h1001_2345, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h9001_2345},
        {32'h1002_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h2ABC_DEF0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h4ABC_DEF0},
        {32'h2ABC_DEF0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h4ABC_DEF0},
        {32'h3006_0010, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h5026_0010},
        {32'h3008_0000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h3000_0000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h2000_1000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 32'h6000_1000},
        {32'h2000_1000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 32'h7000_1000},
        {32'h0ABC_D123, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 32'h1ABC_D123},
        {32'h0ABC_D123, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h2000_1000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h4000_1000},
        {32'h1001_2345, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h1001_2345, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h9001_2345}
    };

    function automatic string row_tag(input int i);
        case (i)
            0:  return "R3/R5/R6 supervisor load rwx";
            1:  return "R5 supervisor store rwx";
            2:  return "R4/R8 user skips entry0";
            3:  return "R3/R9 mid bits mismatch miss";
            4:  return "R3/R6 full mask user load";
            5:  return "R5 store to read-exec faults";
            6:  return "R5/R6 partial mask code 0 faults";
            7:  return "R3 outside partial mask miss";
            8:  return "R4 user-only entry skipped";
            9:  return "R8 first entry faults and stops";
            10: return "R4/R8 user fetch reaches entry1";
            11: return "R6/R7 fetch full mask";
            12: return "R7 load does not use fetch set";
            13: return "R7 load uses data set";
            14: return "R7 fetch does not use data set";
            default: return "R4 user store via entry2";
        endcase
    endfunction

    task automatic wr_word(input bit sp, input int idx, input bit half, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_space = sp; cfg_idx = IDX_W'(idx); cfg_half = half; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_rsp(input string tag, input logic h, input logic g,
                             input logic f, input logic [31:0] ra);
        n_checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== h || rsp_grant !== g ||
            rsp_fault !== f || rsp_raddr !== ra) begin
            n_fails++;
            $display("FAIL %s: got v=%b h=%b g=%b f=%b ra=%h, want v=1 h=%b g=%b f=%b ra=%h",
                     tag, rsp_valid, rsp_hit, rsp_grant, rsp_fault, rsp_raddr, h, g, f, ra);
        end
    endtask

    task automatic lookup(input logic [31:0] ea, input logic [1:0] k, input logic u,
                          input string tag, input logic h, input logic g,
                          input logic f, input logic [31:0] ra);
        @(negedge clk);
        req_valid = 1'b1; req_ea = ea; req_kind = k; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(tag, h, g, f, ra);
    endtask

    task automatic check_idle(input string tag);
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_grant !== 1'b0 ||
            rsp_fault !== 1'b0 || rsp_raddr !== 32'd0) begin
            n_fails++;
            $display("FAIL %s: got v=%b h=%b g=%b f=%b ra=%h, want all zero",
                     tag, rsp_valid, rsp_hit, rsp_grant, rsp_fault, rsp_raddr);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R2 watchdog: got no completion, want completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1/R11: reset state
        check_idle("R11 idle after reset");
        lookup(32'h1001_2345, 2'd0, 1'b0, "R1 empty after reset", 1'b0, 1'b0, 1'b0, 32'h0);
        lookup(32'h0000_0000, 2'd2, 1'b0, "R1 empty fetch set", 1'b0, 1'b0, 1'b0, 32'h0);

        // data set
        wr_word(1'b0, 0, 1'b0, 32'h1000_0002); wr_word(1'b0, 0, 1'b1, 32'h8000_0002);
        wr_word(1'b0, 1, 1'b0, 32'h2000_1FFF); wr_word(1'b0, 1, 1'b1, 32'h4000_0001);
        wr_word(1'b0, 2, 1'b0, 32'h1000_0003); wr_word(1'b0, 2, 1'b1, 32'h9000_0002);
        wr_word(1'b0, 3, 1'b0, 32'h3000_000D); wr_word(1'b0, 3, 1'b1, 32'h5020_0000);
        // instruction set
        wr_word(1'b1, 0, 1'b0, 32'h2000_0002); wr_word(1'b1, 0, 1'b1, 32'h6000_0000);
        wr_word(1'b1, 1, 1'b0, 32'h2000_0003); wr_word(1'b1, 1, 1'b1, 32'h7000_0003);
        wr_word(1'b1, 3, 1'b0, 32'h0000_1FFE); wr_word(1'b1, 3, 1'b1, 32'h1000_0002);

        for (int i = 0; i < N_VEC; i++) begin
            lookup(VEC[i][69:38], VEC[i][37:36], VEC[i][35], row_tag(i),
                   VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]);
        end

        check_idle("R11 quiet without request");

        // R10: write and lookup in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_space = 1'b0; cfg_idx = 2'd0; cfg_half = 1'b0; cfg_wdata = 32'h0;
        req_valid = 1'b1; req_ea = 32'h1001_2345; req_kind = 2'd0; req_user = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        check_rsp("R10 same-cycle lookup sees old entry", 1'b1, 1'b1, 1'b0, 32'h8001_2345);
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R10/R8 next lookup sees write, falls to entry2", 1'b1, 1'b1, 1'b0, 32'h9001_2345);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule